// File: doc/BRIEF.md
# Slot-Mapped Stereo Serial Audio Port

This block is a frame-based synchronous serial port for 16-bit stereo audio. It generates a bit clock and a left/right frame sync from the system clock. It sends a left and a right word on a transmit line and receives a left and a right word from a receive line. The frame holds either two 16-bit slots (32 bits) or four 16-bit slots (64 bits). Each of the four audio directions has its own enable and its own 4-bit slot number. Transmit and receive can therefore share slots or use different slots of the same frame. Two control channels also carry an enable and a slot number. An enabled control channel reserves its slot, so audio is neither sent nor captured there. A disabled control channel reserves nothing.

Transmit words enter through a valid/ready stream that carries one left/right pair per transfer. `tx_ready` is high while the holding pair is free. A pair is taken on any clock where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and the data are ignored, and the source must hold them. Received pairs leave through a valid/ready stream. `rx_valid` rises at the end of each frame and stays high until `rx_ready` is seen. The receive side cannot stall the serial line. If a frame ends before the previous pair has been taken, the newer pair replaces it and the sticky `overrun` flag is set.

The configuration inputs are expected to stay stable while `en` is high. When `en` goes low the port stops and its lines go quiet. When `en` rises the next frame starts at bit 0 of slot 0.

Top module: `stereo_slot_port`

## Requirements
- R1: Every slot is 16 bits, sent and received most-significant bit first. Slot k occupies frame bits 16k to 16k+15. The frame is 32 bits (slots 0 and 1) when `frame64` is 0 and 64 bits (slots 0 to 3) when `frame64` is 1.
- R2: `sync` is high for the first half of each frame and low for the second half. The first bit of slot 0 is on the line in the same bit period in which `sync` goes high.
- R3: `sck` is low when idle, and each of its half periods lasts DIV_HALF clocks. `rxd` is sampled on the clock where `sck` rises. `txd` and `sync` change only where `sck` falls or where a frame starts.
- R4: When enabled, the left transmit word goes out in the slot named by `tx_l_slot` and the right transmit word in the slot named by `tx_r_slot`. If both name the same slot, left wins. A slot number outside the current frame carries nothing.
- R5: `txd` is 0 during any slot that no enabled transmit channel owns.
- R6: The left and right receive words are taken from the slots named by `rx_l_slot` and `rx_r_slot`, independently of the transmit slots. Bits in other slots are ignored. A receive channel that is disabled or maps outside the frame keeps its previous word, which is 0 after reset.
- R7: An enabled control channel whose slot number matches a slot claims that slot: `txd` is 0 there and no audio word is captured from it. A disabled control channel claims no slot, whatever its slot field holds.
- R8: `tx_ready` is high while the holding pair is empty. A pair is accepted when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and the data on `tx_left`/`tx_right` have no effect.
- R9: The holding pair is freed (`tx_ready` returns high) once every enabled transmit channel has been loaded into its slot. If no new pair arrives, the next frame sends the previous words again.
- R10: At the end of each frame in which at least one receive channel is enabled, `rx_valid` goes high with the left and right words. It stays high until `rx_ready` is seen high.
- R11: If a frame ends while `rx_valid` is high and `rx_ready` is low, `overrun` goes high, the newest words replace the old ones, and `overrun` stays high until reset.
- R12: While `en` is low, `sck`, `sync` and `txd` are 0. Raising `en` starts a frame at bit 0 of slot 0.
- R13: After reset `tx_ready` is 1, and `rx_valid`, `overrun`, `rx_left`, `rx_right`, `sck`, `sync` and `txd` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the port; low stops it and idles the lines |
| frame64 | input | 1 | 0 selects a 32-bit frame, 1 a 64-bit frame |
| tx_l_en | input | 1 | Left transmit enable |
| tx_l_slot | input | 4 | Left transmit slot number |
| tx_r_en | input | 1 | Right transmit enable |
| tx_r_slot | input | 4 | Right transmit slot number |
| rx_l_en | input | 1 | Left receive enable |
| rx_l_slot | input | 4 | Left receive slot number |
| rx_r_en | input | 1 | Right receive enable |
| rx_r_slot | input | 4 | Right receive slot number |
| ctl0_en | input | 1 | Control channel 0 enable |
| ctl0_slot | input | 4 | Control channel 0 slot number |
| ctl1_en | input | 1 | Control channel 1 enable |
| ctl1_slot | input | 4 | Control channel 1 slot number |
| tx_valid | input | 1 | Transmit pair valid |
| tx_ready | output | 1 | Holding pair free |
| tx_left | input | WORD_W | Left transmit word |
| tx_right | input | WORD_W | Right transmit word |
| rx_valid | output | 1 | Received pair valid |
| rx_ready | input | 1 | Consumer takes the received pair |
| rx_left | output | WORD_W | Left received word |
| rx_right | output | WORD_W | Right received word |
| overrun | output | 1 | Sticky receive overrun flag |
| sck | output | 1 | Bit clock |
| sync | output | 1 | Left/right frame sync |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The hardest situation to reach is a run of two consecutive frames with no new transmit pair and no read of the receive pair. That run is needed both to show that the previous words are sent again and to raise the overrun flag. The bench gets there by pushing a single pair, holding `rx_ready` low, and acting as the serial peer for two full frames in one pass. It captures every transmit bit of both frames. A slot reserved by a control channel that also carries audio is the other hard case. The bench builds it with a vector where a transmit channel and a receive channel share a slot with an enabled control channel. It then checks that the slot stays silent, that nothing is captured from it, and that the holding pair is never freed.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int SLOT_FW   = 4;
  localparam int MAX_SLOTS = 4;

  typedef struct packed {
    logic               en;
    logic [SLOT_FW-1:0] slot;
  } chan_cfg_t;

  function automatic logic slot_hit(chan_cfg_t c, logic [SLOT_FW-1:0] s);
    return c.en && (c.slot == s);
  endfunction
endpackage

// File: rtl/spk_bitclk.sv
module spk_bitclk #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sck,
  output logic running,
  output logic start,
  output logic rise,
  output logic fall
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DW-1:0] div_cnt;
  logic          tick;

  assign tick  = running && en && (div_cnt == DW'(DIV_HALF - 1));
  assign start = en && !running;
  assign rise  = tick && !sck;
  assign fall  = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      sck     <= 1'b0;
      div_cnt <= '0;
    end else if (!en) begin
      running <= 1'b0;
      sck     <= 1'b0;
      div_cnt <= '0;
    end else if (!running) begin
      running <= 1'b1;
      div_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      sck     <= ~sck;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  AST_NO_EDGE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sck) else $error("bit clock left idle level at frame start"); // R12
endmodule

// File: rtl/spk_framer.sv
module spk_framer #(
  parameter int WORD_W    = 16,
  parameter int MAX_SLOTS = 4,
  parameter int POS_W     = $clog2(WORD_W * MAX_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             running,
  input  logic             start,
  input  logic             fall,
  input  logic             frame64,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] nxt_pos,
  output logic             advance,
  output logic             last_bit,
  output logic             sync
);
  localparam int FRAME_MAX = WORD_W * MAX_SLOTS;

  logic [POS_W-1:0] last_p;
  logic [POS_W-1:0] half_p;

  assign last_p   = frame64 ? POS_W'(FRAME_MAX - 1) : POS_W'(FRAME_MAX / 2 - 1);
  assign half_p   = frame64 ? POS_W'(FRAME_MAX / 2) : POS_W'(FRAME_MAX / 4);
  assign advance  = start || fall;
  assign last_bit = (pos == last_p);
  assign nxt_pos  = (start || last_bit) ? '0 : pos + 1'b1;
  assign sync     = running && (pos < half_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (!en)     pos <= '0;
    else if (advance) pos <= nxt_pos;
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pos <= last_p)) else $error("bit position past frame end"); // R1
endmodule

// File: rtl/spk_slotmap.sv
module spk_slotmap
  import spk_pkg::*;
#(
  parameter int SIDX_W = 2
) (
  input  logic [SIDX_W-1:0] sidx,
  input  chan_cfg_t         cfg_l,
  input  chan_cfg_t         cfg_r,
  input  chan_cfg_t         ctl0,
  input  chan_cfg_t         ctl1,
  output logic              sel_l,
  output logic              sel_r
);
  logic [SLOT_FW-1:0] s_ext;
  logic               claimed;

  assign s_ext   = SLOT_FW'(sidx);
  assign claimed = slot_hit(ctl0, s_ext) || slot_hit(ctl1, s_ext);
  assign sel_l   = !claimed && slot_hit(cfg_l, s_ext);
  assign sel_r   = !claimed && !sel_l && slot_hit(cfg_r, s_ext);
endmodule

// File: rtl/spk_tx.sv
module spk_tx #(
  parameter int WORD_W = 16,
  parameter int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              advance,
  input  logic [BIT_W-1:0]  nxt_bit,
  input  logic              sel_l,
  input  logic              sel_r,
  input  logic              l_en,
  input  logic              r_en,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              tx_ready,
  output logic              txd
);
  logic [WORD_W-1:0] hold_l, hold_r, sh;
  logic              full, taken_l, taken_r;
  logic              slot_start, taken_l_n, taken_r_n, done;

  assign slot_start = advance && (nxt_bit == '0);
  assign taken_l_n  = taken_l || (slot_start && sel_l && full);
  assign taken_r_n  = taken_r || (slot_start && sel_r && full);
  assign done       = full && advance && (taken_l_n || !l_en) && (taken_r_n || !r_en);
  assign tx_ready   = !full;
  assign txd        = sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l  <= '0;
      hold_r  <= '0;
      full    <= 1'b0;
      taken_l <= 1'b0;
      taken_r <= 1'b0;
    end else if (tx_valid && !full) begin
      hold_l  <= tx_left;
      hold_r  <= tx_right;
      full    <= 1'b1;
      taken_l <= 1'b0;
      taken_r <= 1'b0;
    end else if (done) begin
      full    <= 1'b0;
      taken_l <= 1'b0;
      taken_r <= 1'b0;
    end else begin
      taken_l <= taken_l_n;
      taken_r <= taken_r_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sh <= '0;
    else if (!run)       sh <= '0;
    else if (slot_start) sh <= sel_l ? hold_l : (sel_r ? hold_r : '0);
    else if (advance)    sh <= {sh[WORD_W-2:0], 1'b0};
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && full) |=> ($stable(hold_l) && $stable(hold_r))) else $error("holding pair overwritten"); // R8
  AST_SILENT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && slot_start && !sel_l && !sel_r) |=> !txd) else $error("unowned slot not silent"); // R5
endmodule

// File: rtl/spk_rx.sv
module spk_rx #(
  parameter int WORD_W = 16,
  parameter int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic [BIT_W-1:0]  bit_in_slot,
  input  logic              last_bit,
  input  logic              sel_l,
  input  logic              sel_r,
  input  logic              any_en,
  input  logic              rxd,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              overrun
);
  logic [WORD_W-1:0] sh, cap_l, cap_r, word_n, cap_l_n, cap_r_n;
  logic              slot_end, frame_end;

  assign word_n    = {sh[WORD_W-2:0], rxd};
  assign slot_end  = rise && (bit_in_slot == '1);
  assign cap_l_n   = (slot_end && sel_l) ? word_n : cap_l;
  assign cap_r_n   = (slot_end && sel_r) ? word_n : cap_r;
  assign frame_end = rise && last_bit && any_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      cap_l <= '0;
      cap_r <= '0;
    end else begin
      if (rise) sh <= word_n;
      cap_l <= cap_l_n;
      cap_r <= cap_r_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
      overrun  <= 1'b0;
    end else if (frame_end) begin
      rx_valid <= 1'b1;
      rx_left  <= cap_l_n;
      rx_right <= cap_r_n;
      if (rx_valid && !rx_ready) overrun <= 1'b1;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  AST_RXV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid) else $error("received pair dropped"); // R10
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && rx_valid && !rx_ready) |=> overrun) else $error("overrun missed"); // R11
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun) else $error("overrun cleared"); // R11
endmodule

// File: rtl/stereo_slot_port.sv
module stereo_slot_port
  import spk_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int DIV_HALF = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               frame64,
  input  logic               tx_l_en,
  input  logic [SLOT_FW-1:0] tx_l_slot,
  input  logic               tx_r_en,
  input  logic [SLOT_FW-1:0] tx_r_slot,
  input  logic               rx_l_en,
  input  logic [SLOT_FW-1:0] rx_l_slot,
  input  logic               rx_r_en,
  input  logic [SLOT_FW-1:0] rx_r_slot,
  input  logic               ctl0_en,
  input  logic [SLOT_FW-1:0] ctl0_slot,
  input  logic               ctl1_en,
  input  logic [SLOT_FW-1:0] ctl1_slot,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [WORD_W-1:0]  tx_left,
  input  logic [WORD_W-1:0]  tx_right,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [WORD_W-1:0]  rx_left,
  output logic [WORD_W-1:0]  rx_right,
  output logic               overrun,
  output logic               sck,
  output logic               sync,
  output logic               txd,
  input  logic               rxd
);
  localparam int FRAME_MAX = WORD_W * MAX_SLOTS;
  localparam int POS_W     = $clog2(FRAME_MAX);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int SIDX_W    = POS_W - BIT_W;

  chan_cfg_t        c_txl, c_txr, c_rxl, c_rxr, c_ctl0, c_ctl1;
  logic             running, start, rise, fall, advance, last_bit;
  logic [POS_W-1:0] pos, nxt_pos;
  logic             tsel_l, tsel_r, rsel_l, rsel_r;

  assign c_txl  = '{en: tx_l_en, slot: tx_l_slot};
  assign c_txr  = '{en: tx_r_en, slot: tx_r_slot};
  assign c_rxl  = '{en: rx_l_en, slot: rx_l_slot};
  assign c_rxr  = '{en: rx_r_en, slot: rx_r_slot};
  assign c_ctl0 = '{en: ctl0_en, slot: ctl0_slot};
  assign c_ctl1 = '{en: ctl1_en, slot: ctl1_slot};

  spk_bitclk #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en), .sck(sck), .running(running),
    .start(start), .rise(rise), .fall(fall));

  spk_framer #(.WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS), .POS_W(POS_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .en(en), .running(running), .start(start),
    .fall(fall), .frame64(frame64), .pos(pos), .nxt_pos(nxt_pos),
    .advance(advance), .last_bit(last_bit), .sync(sync));

  spk_slotmap #(.SIDX_W(SIDX_W)) u_tmap (
    .sidx(nxt_pos[POS_W-1:BIT_W]), .cfg_l(c_txl), .cfg_r(c_txr),
    .ctl0(c_ctl0), .ctl1(c_ctl1), .sel_l(tsel_l), .sel_r(tsel_r));

  spk_slotmap #(.SIDX_W(SIDX_W)) u_rmap (
    .sidx(pos[POS_W-1:BIT_W]), .cfg_l(c_rxl), .cfg_r(c_rxr),
    .ctl0(c_ctl0), .ctl1(c_ctl1), .sel_l(rsel_l), .sel_r(rsel_r));

  spk_tx #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .run(en), .advance(advance),
    .nxt_bit(nxt_pos[BIT_W-1:0]), .sel_l(tsel_l), .sel_r(tsel_r),
    .l_en(tx_l_en), .r_en(tx_r_en), .tx_valid(tx_valid),
    .tx_left(tx_left), .tx_right(tx_right), .tx_ready(tx_ready), .txd(txd));

  spk_rx #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rise(rise), .bit_in_slot(pos[BIT_W-1:0]),
    .last_bit(last_bit), .sel_l(rsel_l), .sel_r(rsel_r),
    .any_en(rx_l_en || rx_r_en), .rxd(rxd), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right),
    .overrun(overrun));

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sck && !sync && !txd)) else $error("lines active while stopped"); // R12
  AST_TXD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !advance) |=> $stable(txd)) else $error("txd moved off a falling edge"); // R3
  AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sync) else $error("sync low at first bit"); // R2
endmodule

// File: tb/sim_stereo_slot_port.sv
module sim_stereo_slot_port;
  typedef struct packed {
    logic f64;
    logic txl_en; logic [3:0] txl_slot;
    logic txr_en; logic [3:0] txr_slot;
    logic rxl_en; logic [3:0] rxl_slot;
    logic rxr_en; logic [3:0] rxr_slot;
    logic c0_en;  logic [3:0] c0_slot;
    logic c1_en;  logic [3:0] c1_slot;
    logic [15:0] txl; logic [15:0] txr;
    logic [63:0] rxv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1,4'd0, 1'b1,4'd1, 1'b1,4'd0, 1'b1,4'd1, 1'b0,4'd0, 1'b0,4'd0, 16'hA5C3, 16'h1E0F, 64'h1234_8001_0000_0000},
    '{1'b1, 1'b1,4'd0, 1'b1,4'd2, 1'b1,4'd1, 1'b1,4'd3, 1'b0,4'd0, 1'b0,4'd0, 16'hBEEF, 16'h0F0F, 64'hAAAA_5A5A_FFFF_C001},
    '{1'b0, 1'b1,4'd1, 1'b1,4'd0, 1'b1,4'd1, 1'b1,4'd0, 1'b0,4'd0, 1'b0,4'd0, 16'h8000, 16'h0001, 64'h7FFE_4321_0000_0000},
    '{1'b1, 1'b1,4'd0, 1'b1,4'd2, 1'b1,4'd2, 1'b1,4'd3, 1'b1,4'd2, 1'b0,4'd0, 16'h6C6C, 16'h3939, 64'h1111_2222_3333_4444},
    '{1'b1, 1'b1,4'd0, 1'b1,4'd1, 1'b1,4'd0, 1'b1,4'd1, 1'b0,4'd0, 1'b0,4'd1, 16'hF00D, 16'h0BAD, 64'hABCD_0123_9999_8888},
    '{1'b1, 1'b0,4'd0, 1'b1,4'd3, 1'b1,4'd5, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 16'h1357, 16'h2468, 64'hDEAD_BEEF_CAFE_F00D}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, frame64 = 1'b0;
  logic tx_l_en = 0, tx_r_en = 0, rx_l_en = 0, rx_r_en = 0, ctl0_en = 0, ctl1_en = 0;
  logic [3:0] tx_l_slot = 0, tx_r_slot = 0, rx_l_slot = 0, rx_r_slot = 0, ctl0_slot = 0, ctl1_slot = 0;
  logic tx_valid = 0, rx_ready = 0, rxd = 0;
  logic [15:0] tx_left = 0, tx_right = 0;
  logic tx_ready, rx_valid, overrun, sck, sync, txd;
  logic [15:0] rx_left, rx_right;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [63:0] captx [0:2];
  logic [63:0] capsy [0:2];

  always #2 clk = ~clk;

  stereo_slot_port #(.WORD_W(16), .DIV_HALF(4)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .frame64(frame64),
    .tx_l_en(tx_l_en), .tx_l_slot(tx_l_slot), .tx_r_en(tx_r_en), .tx_r_slot(tx_r_slot),
    .rx_l_en(rx_l_en), .rx_l_slot(rx_l_slot), .rx_r_en(rx_r_en), .rx_r_slot(rx_r_slot),
    .ctl0_en(ctl0_en), .ctl0_slot(ctl0_slot), .ctl1_en(ctl1_en), .ctl1_slot(ctl1_slot),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_left(rx_left), .rx_right(rx_right),
    .overrun(overrun), .sck(sck), .sync(sync), .txd(txd), .rxd(rxd));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit claimed(vec_t v, int s);
    return (v.c0_en && v.c0_slot == s) || (v.c1_en && v.c1_slot == s);
  endfunction

  function automatic int nslots(vec_t v);
    return v.f64 ? 4 : 2;
  endfunction

  function automatic logic [63:0] exp_tx(vec_t v);
    logic [63:0] f = '0;
    for (int s = 0; s < nslots(v); s++) begin
      if (claimed(v, s)) f[63-16*s -: 16] = 16'h0;
      else if (v.txl_en && v.txl_slot == s) f[63-16*s -: 16] = v.txl;
      else if (v.txr_en && v.txr_slot == s) f[63-16*s -: 16] = v.txr;
    end
    return f;
  endfunction

  function automatic logic [63:0] exp_sync(vec_t v);
    logic [63:0] f = '0;
    for (int k = 0; k < 8 * nslots(v); k++) f[63-k] = 1'b1;
    return f;
  endfunction

  function automatic logic [15:0] exp_rx(vec_t v, bit chan_en, int sl);
    if (!chan_en || sl >= nslots(v) || claimed(v, sl)) return 16'h0;
    return v.rxv[63-16*sl -: 16];
  endfunction

  function automatic bit loads(vec_t v, bit chan_en, int sl);
    return chan_en && sl < nslots(v) && !claimed(v, sl);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; en = 0; tx_valid = 0; rx_ready = 0; rxd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic apply(vec_t v);
    frame64 = v.f64;
    tx_l_en = v.txl_en; tx_l_slot = v.txl_slot;
    tx_r_en = v.txr_en; tx_r_slot = v.txr_slot;
    rx_l_en = v.rxl_en; rx_l_slot = v.rxl_slot;
    rx_r_en = v.rxr_en; rx_r_slot = v.rxr_slot;
    ctl0_en = v.c0_en;  ctl0_slot = v.c0_slot;
    ctl1_en = v.c1_en;  ctl1_slot = v.c1_slot;
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    tx_left = l; tx_right = r; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
  endtask

  // acts as the serial peer for n frames; stops the port right after the last rising edge
  task automatic run_frames(input int n, input logic [63:0] rxv, input bit f64);
    int len;
    len = f64 ? 64 : 32;
    for (int f = 0; f < 3; f++) begin captx[f] = '0; capsy[f] = '0; end
    rxd = rxv[63];
    @(negedge clk);
    en = 1;
    for (int f = 0; f < n; f++) begin
      for (int k = 0; k < len; k++) begin
        @(posedge sck);
        #1;
        captx[f][63-k] = txd;
        capsy[f][63-k] = sync;
        rxd = rxv[63 - ((k + 1) % len)];
      end
    end
    @(negedge clk);
    @(negedge clk);
    en = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    vec_t v;
    // R13 reset values
    do_reset();
    chk(tx_ready === 1'b1, "R13 tx_ready", 64'(tx_ready), 64'd1);
    chk({rx_valid, overrun} === 2'b00, "R13 rx_valid/overrun", 64'({rx_valid, overrun}), 64'd0);
    chk({rx_left, rx_right} === 32'h0, "R13 rx words", 64'({rx_left, rx_right}), 64'd0);
    chk({sck, sync, txd} === 3'b000, "R13 lines", 64'({sck, sync, txd}), 64'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      do_reset();
      apply(v);
      push(v.txl, v.txr);
      run_frames(1, v.rxv, v.f64);
      chk(captx[0] === exp_tx(v), $sformatf("R1/R4/R5/R7 tx frame v%0d", i), captx[0], exp_tx(v));
      chk(capsy[0] === exp_sync(v), $sformatf("R2 sync v%0d", i), capsy[0], exp_sync(v));
      chk({rx_left, rx_right} === {exp_rx(v, v.rxl_en, int'(v.rxl_slot)), exp_rx(v, v.rxr_en, int'(v.rxr_slot))},
          $sformatf("R6/R7 rx words v%0d", i), 64'({rx_left, rx_right}),
          64'({exp_rx(v, v.rxl_en, int'(v.rxl_slot)), exp_rx(v, v.rxr_en, int'(v.rxr_slot))}));
      chk(rx_valid === 1'b1, $sformatf("R10 rx_valid v%0d", i), 64'(rx_valid), 64'd1);
      chk(overrun === 1'b0, $sformatf("R11 no overrun v%0d", i), 64'(overrun), 64'd0);
      chk(tx_ready === ((!v.txl_en || loads(v, 1'b1, int'(v.txl_slot))) && (!v.txr_en || loads(v, 1'b1, int'(v.txr_slot)))),
          $sformatf("R9 tx_ready v%0d", i), 64'(tx_ready),
          64'((!v.txl_en || loads(v, 1'b1, int'(v.txl_slot))) && (!v.txr_en || loads(v, 1'b1, int'(v.txr_slot)))));
      @(negedge clk); rx_ready = 1;
      @(negedge clk); rx_ready = 0;
      chk(rx_valid === 1'b0, $sformatf("R10 rx_valid drop v%0d", i), 64'(rx_valid), 64'd0);
    end

    // R12 idle lines after stopping
    chk({sck, sync, txd} === 3'b000, "R12 idle lines", 64'({sck, sync, txd}), 64'd0);

    // R3 half period of the bit clock
    do_reset();
    apply(VEC[0]);
    @(negedge clk); en = 1;
    @(posedge sck);
    cnt = 0;
    do begin
      @(posedge clk); #1; cnt++;
    end while (sck === 1'b1 && cnt < 20);
    chk(cnt == 4, "R3 sck high time", 64'(cnt), 64'd4);
    @(negedge clk); en = 0;

    // R8 back-pressure: second offer while full is ignored
    do_reset();
    v = VEC[0];
    apply(v);
    push(16'hC0DE, 16'h5EED);
    @(negedge clk);
    tx_left = 16'hFFFF; tx_right = 16'hFFFF; tx_valid = 1;
    repeat (3) @(negedge clk);
    chk(tx_ready === 1'b0, "R8 tx_ready low when full", 64'(tx_ready), 64'd0);
    tx_valid = 0;
    run_frames(1, v.rxv, v.f64);
    chk(captx[0][63:32] === 32'hC0DE_5EED, "R8 ignored offer", captx[0][63:32], 64'hC0DE_5EED);

    // R9 repeat and R11 overrun over two unread frames
    do_reset();
    v = VEC[1];
    apply(v);
    push(16'h9A9A, 16'h0770);
    run_frames(2, v.rxv, v.f64);
    chk(captx[1] === captx[0] && captx[0] === 64'h9A9A_0000_0770_0000, "R9 repeat words", captx[1], 64'h9A9A_0000_0770_0000);
    chk(overrun === 1'b1, "R11 overrun set", 64'(overrun), 64'd1);
    chk({rx_left, rx_right} === {16'h5A5A, 16'hC001}, "R11 newest words", 64'({rx_left, rx_right}), 64'h5A5A_C001);
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
    chk(overrun === 1'b1, "R11 overrun sticky", 64'(overrun), 64'd1);

    // R12 restart begins at slot 0 bit 0
    run_frames(1, v.rxv, v.f64);
    chk(captx[0] === 64'h9A9A_0000_0770_0000 && capsy[0] === exp_sync(v), "R12 restart alignment",
        captx[0], 64'h9A9A_0000_0770_0000);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule